// File: doc/BRIEF.md
# Burst Copy Engine Between External Memory and Local RAM

This block copies 128-bit data between an external memory, reached over an AXI4 master port, and a block RAM held inside it. Software sets up a command through a 64-bit register port that holds pairs of 32-bit registers. A command gives an external start address, a beat count per burst, a number of bursts, a local RAM start entry and a direction. The engine then issues the bursts one after another with INCR addressing. Each request carries cache and user sideband values that software sets.

When the final burst of a command is complete, a sticky done flag is set. Software polls for it and then clears it with a command bit. For writes out to memory, the local RAM is read one cycle ahead into a single holding register. This keeps WVALID and WDATA steady while the slave holds WREADY low, and still allows one beat per cycle when the slave does not stall.

Top module: `burst_copy_engine`

## Requirements
- R1: After reset, ARVALID, AWVALID and WVALID are low and every register reads back as 0.
- R2: 32-bit register n sits in 64-bit word n/2, in the low half when n is even and in the high half when n is odd. The registers are: n=0 status (bit 0 done), n=1 command (reads 0), n=2 external address, n=3 beats-per-burst minus one (8 bits), n=4 burst count (16 bits), n=5 local RAM start entry (11 bits), n=29 cache (4 bits), n=30 user (2 bits). Each write strobe bit updates only its own byte.
- R3: A read command issues exactly the programmed number of AR requests. The first ARADDR is the programmed address, and each later one is higher by (length+1)×16. ARLEN equals the length register, ARSIZE is 4, ARBURST is 1 (INCR), and ARCACHE and ARUSER equal the cache and user registers.
- R4: Read beats are stored in local RAM at consecutive entries starting at the programmed start entry, across all bursts.
- R5: A write command issues AW requests addressed in the same way as R3. The W beats carry the local RAM entries in order from the start entry. WLAST marks the final beat of each burst, and WSTRB is all ones.
- R6: While WVALID is high and WREADY is low, WVALID stays high and WDATA and WLAST hold their values on the next cycle.
- R7: The done flag (status bit 0) goes to 1 only in the cycle after the last RLAST beat is accepted (read) or the last B response is accepted (write).
- R8: The done flag stays at 1 until a command write with bit 31 set. If the flag is set and cleared in the same cycle, it ends at 1.
- R9: A start command written while a command is in progress is ignored.
- R10: A start command with a burst count of 0 sets the done flag on the next cycle and issues no request.
- R11: A command write with bits 0 and 1 both set starts a read, not a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write enable |
| regWrAddr | input | 4 | 64-bit word index for writes |
| regWrData | input | 64 | Register write data |
| regWrStrb | input | 8 | Byte strobes for writes |
| regRdAddr | input | 4 | 64-bit word index for reads |
| regRdData | output | 64 | Combinational read data |
| arvalid | output | 1 | Read address valid |
| arready | input | 1 | Read address ready |
| araddr | output | 32 | Read address |
| arlen | output | 8 | Read burst length minus one |
| arsize | output | 3 | Read beat size code |
| arburst | output | 2 | Read burst type |
| arcache | output | 4 | Read cache attribute |
| aruser | output | 2 | Read user sideband |
| rvalid | input | 1 | Read data valid |
| rready | output | 1 | Read data ready |
| rdata | input | 128 | Read data |
| rlast | input | 1 | Last read beat |
| awvalid | output | 1 | Write address valid |
| awready | input | 1 | Write address ready |
| awaddr | output | 32 | Write address |
| awlen | output | 8 | Write burst length minus one |
| awsize | output | 3 | Write beat size code |
| awburst | output | 2 | Write burst type |
| awcache | output | 4 | Write cache attribute |
| awuser | output | 2 | Write user sideband |
| wvalid | output | 1 | Write data valid |
| wready | input | 1 | Write data ready |
| wdata | output | 128 | Write data |
| wstrb | output | 16 | Write byte strobes |
| wlast | output | 1 | Last write beat |
| bvalid | input | 1 | Write response valid |
| bready | output | 1 | Write response ready |

## Verification
The done flag can be set and cleared in the same cycle. The bench provokes this by programming a burst count of zero and then writing a single command word that both starts a read and clears the flag. The start then raises the set request on the same edge as the clear, and the bench requires the flag to read 1 afterwards. A second overlap is W backpressure arriving on the cycle a RAM prefetch would refill the holding register. A slave that withholds WREADY in a repeating pattern produces this, and the bench checks that every beat keeps its value across the stall and arrives in RAM order.

// File: rtl/bce_pkg.sv
package bce_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_RD_ADDR, S_RD_DATA, S_WR_ADDR, S_WR_DATA, S_WR_RESP
  } bceState_t;

  typedef struct packed {
    logic loadCfg;
    logic ramWrite;
    logic ramFetch;
    logic wTake;
    logic burstDone;
    logic setDone;
  } bceStrobe_t;

  localparam int REG_STATUS = 0;
  localparam int REG_CMD    = 1;
  localparam int REG_EXT    = 2;
  localparam int REG_LEN    = 3;
  localparam int REG_CNT    = 4;
  localparam int REG_RAM    = 5;
  localparam int REG_CACHE  = 29;
  localparam int REG_USER   = 30;

  function automatic logic [31:0] mergeBytes(input logic [31:0] oldVal,
                                             input logic [31:0] newVal,
                                             input logic [3:0] be);
    logic [31:0] res;
    res = oldVal;
    for (int b = 0; b < 4; b++)
      if (be[b]) res[8*b +: 8] = newVal[8*b +: 8];
    return res;
  endfunction

endpackage

// File: rtl/bce_ctrl.sv
module bce_ctrl
  import bce_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startRd,
  input  logic             startWr,
  input  logic [CNT_W-1:0] cfgCount,
  input  logic [LEN_W-1:0] cfgLen,
  input  logic             wBufValid,
  input  logic             arready,
  input  logic             rvalid,
  input  logic             rlast,
  input  logic             awready,
  input  logic             wready,
  input  logic             bvalid,
  output logic [LEN_W-1:0] lenQ,
  output logic             arvalid,
  output logic             rready,
  output logic             awvalid,
  output logic             wvalid,
  output logic             wlast,
  output logic             bready,
  output bceStrobe_t       strb
);

  localparam int FL_W = LEN_W + 1;

  bceState_t        st;
  logic [CNT_W-1:0] burstsLeft;
  logic [LEN_W-1:0] beatLeft;
  logic [FL_W-1:0]  fetchLeft;

  logic rBeat, wTake, bHs, launch, zeroCnt, lastBurst;

  always_comb begin
    arvalid   = (st == S_RD_ADDR);
    rready    = (st == S_RD_DATA);
    awvalid   = (st == S_WR_ADDR);
    wvalid    = (st == S_WR_DATA) && wBufValid;
    wlast     = wvalid && (beatLeft == '0);
    bready    = (st == S_WR_RESP);
    rBeat     = rvalid && rready;
    wTake     = wvalid && wready;
    bHs       = bvalid && bready;
    launch    = (st == S_IDLE) && (startRd || startWr);
    zeroCnt   = (cfgCount == '0);
    lastBurst = (burstsLeft == CNT_W'(1));

    strb.loadCfg   = launch && !zeroCnt;
    strb.ramWrite  = rBeat;
    strb.wTake     = wTake;
    strb.ramFetch  = ((st == S_WR_ADDR) || (st == S_WR_DATA)) &&
                     (fetchLeft != '0) && (!wBufValid || wTake);
    strb.burstDone = (rBeat && rlast) || bHs;
    strb.setDone   = (launch && zeroCnt) || (strb.burstDone && lastBurst);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st         <= S_IDLE;
      burstsLeft <= '0;
      beatLeft   <= '0;
      fetchLeft  <= '0;
      lenQ       <= '0;
    end else begin
      if (strb.ramFetch) fetchLeft <= fetchLeft - FL_W'(1);
      case (st)
        S_IDLE: if (launch && !zeroCnt) begin
          burstsLeft <= cfgCount;
          lenQ       <= cfgLen;
          if (startRd) st <= S_RD_ADDR;
          else begin
            st        <= S_WR_ADDR;
            fetchLeft <= {1'b0, cfgLen} + FL_W'(1);
          end
        end
        S_RD_ADDR: if (arready) st <= S_RD_DATA;
        S_RD_DATA: if (rBeat && rlast) begin
          if (lastBurst) st <= S_IDLE;
          else begin
            burstsLeft <= burstsLeft - CNT_W'(1);
            st         <= S_RD_ADDR;
          end
        end
        S_WR_ADDR: if (awready) begin
          st       <= S_WR_DATA;
          beatLeft <= lenQ;
        end
        S_WR_DATA: if (wTake) begin
          if (beatLeft == '0) st <= S_WR_RESP;
          else beatLeft <= beatLeft - LEN_W'(1);
        end
        S_WR_RESP: if (bHs) begin
          if (lastBurst) st <= S_IDLE;
          else begin
            burstsLeft <= burstsLeft - CNT_W'(1);
            fetchLeft  <= {1'b0, lenQ} + FL_W'(1);
            st         <= S_WR_ADDR;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/bce_dpath.sv
module bce_dpath
  import bce_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 128,
  parameter int RAM_AW = 11,
  parameter int CNT_W  = 16,
  parameter int LEN_W  = 8,
  parameter int USER_W = 2,
  parameter int RA_W   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [RA_W-1:0]   regWrAddr,
  input  logic [63:0]       regWrData,
  input  logic [7:0]        regWrStrb,
  input  logic [RA_W-1:0]   regRdAddr,
  output logic [63:0]       regRdData,
  input  bceStrobe_t        strb,
  input  logic [LEN_W-1:0]  lenQ,
  input  logic [DATA_W-1:0] rdata,
  output logic              startRd,
  output logic              startWr,
  output logic [CNT_W-1:0]  cfgCount,
  output logic [LEN_W-1:0]  cfgLen,
  output logic [3:0]        cfgCache,
  output logic [USER_W-1:0] cfgUser,
  output logic [ADDR_W-1:0] extPtr,
  output logic [DATA_W-1:0] wBuf,
  output logic              wBufValid,
  output logic              doneFlag
);

  localparam int RAM_DEPTH = 1 << RAM_AW;
  localparam int BEAT_SH   = $clog2(DATA_W / 8);
  localparam int IDX_W     = RA_W + 1;

  logic [ADDR_W-1:0] cfgAddr;
  logic [RAM_AW-1:0] cfgRam;
  logic [RAM_AW-1:0] ramPtr;
  logic [DATA_W-1:0] mem [RAM_DEPTH];
  logic              cmdHit, clrDone;
  logic [31:0]       rdHalf [2];

  always_comb begin
    cmdHit  = regWrEn && (regWrAddr == RA_W'(REG_CMD / 2));
    startRd = cmdHit && regWrStrb[4] && regWrData[32];
    startWr = cmdHit && regWrStrb[4] && regWrData[33];
    clrDone = cmdHit && regWrStrb[7] && regWrData[63];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgAddr  <= '0;
      cfgLen   <= '0;
      cfgCount <= '0;
      cfgRam   <= '0;
      cfgCache <= '0;
      cfgUser  <= '0;
    end else if (regWrEn) begin
      for (int h = 0; h < 2; h++) begin
        logic [IDX_W-1:0] idx;
        logic [31:0]      dIn;
        logic [3:0]       be;
        idx = {regWrAddr, 1'b0} + IDX_W'(h);
        dIn = regWrData[32*h +: 32];
        be  = regWrStrb[4*h +: 4];
        case (int'(idx))
          REG_EXT:   cfgAddr  <= ADDR_W'(mergeBytes(32'(cfgAddr), dIn, be));
          REG_LEN:   cfgLen   <= LEN_W'(mergeBytes(32'(cfgLen), dIn, be));
          REG_CNT:   cfgCount <= CNT_W'(mergeBytes(32'(cfgCount), dIn, be));
          REG_RAM:   cfgRam   <= RAM_AW'(mergeBytes(32'(cfgRam), dIn, be));
          REG_CACHE: cfgCache <= 4'(mergeBytes(32'(cfgCache), dIn, be));
          REG_USER:  cfgUser  <= USER_W'(mergeBytes(32'(cfgUser), dIn, be));
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) doneFlag <= 1'b0;
    else if (strb.setDone) doneFlag <= 1'b1;
    else if (clrDone) doneFlag <= 1'b0;
  end

  always_comb begin
    for (int h = 0; h < 2; h++) begin
      logic [IDX_W-1:0] idx;
      idx = {regRdAddr, 1'b0} + IDX_W'(h);
      case (int'(idx))
        REG_STATUS: rdHalf[h] = {31'b0, doneFlag};
        REG_EXT:    rdHalf[h] = 32'(cfgAddr);
        REG_LEN:    rdHalf[h] = 32'(cfgLen);
        REG_CNT:    rdHalf[h] = 32'(cfgCount);
        REG_RAM:    rdHalf[h] = 32'(cfgRam);
        REG_CACHE:  rdHalf[h] = 32'(cfgCache);
        REG_USER:   rdHalf[h] = 32'(cfgUser);
        default:    rdHalf[h] = '0;
      endcase
    end
    regRdData = {rdHalf[1], rdHalf[0]};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      extPtr    <= '0;
      ramPtr    <= '0;
      wBufValid <= 1'b0;
    end else begin
      if (strb.loadCfg) begin
        extPtr <= cfgAddr;
        ramPtr <= cfgRam;
      end else begin
        if (strb.burstDone)
          extPtr <= extPtr + ((ADDR_W'(lenQ) + ADDR_W'(1)) << BEAT_SH);
        if (strb.ramWrite || strb.ramFetch)
          ramPtr <= ramPtr + RAM_AW'(1);
      end
      if (strb.ramFetch) wBufValid <= 1'b1;
      else if (strb.wTake) wBufValid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.ramWrite) mem[ramPtr] <= rdata;
    if (strb.ramFetch) wBuf <= mem[ramPtr];
  end

endmodule

// File: rtl/burst_copy_engine.sv
module burst_copy_engine
  import bce_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 128,
  parameter int RAM_AW = 11,
  parameter int CNT_W  = 16,
  parameter int LEN_W  = 8,
  parameter int USER_W = 2,
  parameter int RA_W   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [RA_W-1:0]   regWrAddr,
  input  logic [63:0]       regWrData,
  input  logic [7:0]        regWrStrb,
  input  logic [RA_W-1:0]   regRdAddr,
  output logic [63:0]       regRdData,
  output logic              arvalid,
  input  logic              arready,
  output logic [ADDR_W-1:0] araddr,
  output logic [LEN_W-1:0]  arlen,
  output logic [2:0]        arsize,
  output logic [1:0]        arburst,
  output logic [3:0]        arcache,
  output logic [USER_W-1:0] aruser,
  input  logic              rvalid,
  output logic              rready,
  input  logic [DATA_W-1:0] rdata,
  input  logic              rlast,
  output logic              awvalid,
  input  logic              awready,
  output logic [ADDR_W-1:0] awaddr,
  output logic [LEN_W-1:0]  awlen,
  output logic [2:0]        awsize,
  output logic [1:0]        awburst,
  output logic [3:0]        awcache,
  output logic [USER_W-1:0] awuser,
  output logic              wvalid,
  input  logic              wready,
  output logic [DATA_W-1:0] wdata,
  output logic [DATA_W/8-1:0] wstrb,
  output logic              wlast,
  input  logic              bvalid,
  output logic              bready
);

  localparam logic [2:0] SIZE_CODE = 3'($clog2(DATA_W / 8));

  bceStrobe_t        strb;
  logic              startRd, startWr, wBufValid, doneFlag;
  logic [CNT_W-1:0]  cfgCount;
  logic [LEN_W-1:0]  cfgLen, lenQ;
  logic [3:0]        cfgCache;
  logic [USER_W-1:0] cfgUser;
  logic [ADDR_W-1:0] extPtr;
  logic [DATA_W-1:0] wBuf;

  bce_ctrl #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .startRd(startRd), .startWr(startWr),
    .cfgCount(cfgCount), .cfgLen(cfgLen), .wBufValid(wBufValid),
    .arready(arready), .rvalid(rvalid), .rlast(rlast), .awready(awready),
    .wready(wready), .bvalid(bvalid), .lenQ(lenQ), .arvalid(arvalid),
    .rready(rready), .awvalid(awvalid), .wvalid(wvalid), .wlast(wlast),
    .bready(bready), .strb(strb)
  );

  bce_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RAM_AW(RAM_AW), .CNT_W(CNT_W),
              .LEN_W(LEN_W), .USER_W(USER_W), .RA_W(RA_W)) u_dpath (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrAddr(regWrAddr),
    .regWrData(regWrData), .regWrStrb(regWrStrb), .regRdAddr(regRdAddr),
    .regRdData(regRdData), .strb(strb), .lenQ(lenQ), .rdata(rdata),
    .startRd(startRd), .startWr(startWr), .cfgCount(cfgCount), .cfgLen(cfgLen),
    .cfgCache(cfgCache), .cfgUser(cfgUser), .extPtr(extPtr), .wBuf(wBuf),
    .wBufValid(wBufValid), .doneFlag(doneFlag)
  );

  always_comb begin
    araddr  = extPtr;
    awaddr  = extPtr;
    arlen   = lenQ;
    awlen   = lenQ;
    arsize  = SIZE_CODE;
    awsize  = SIZE_CODE;
    arburst = 2'b01;
    awburst = 2'b01;
    arcache = cfgCache;
    awcache = cfgCache;
    aruser  = cfgUser;
    awuser  = cfgUser;
    wdata   = wBuf;
    wstrb   = '1;
  end

endmodule

// File: rtl/bce_checker.sv
module bce_checker #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 128,
  parameter int LEN_W  = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic [3:0]        regWrAddr,
  input logic [63:0]       regWrData,
  input logic [7:0]        regWrStrb,
  input logic              arvalid,
  input logic              arready,
  input logic [ADDR_W-1:0] araddr,
  input logic [LEN_W-1:0]  arlen,
  input logic              awvalid,
  input logic              awready,
  input logic [ADDR_W-1:0] awaddr,
  input logic              rvalid,
  input logic              rready,
  input logic              rlast,
  input logic              wvalid,
  input logic              wready,
  input logic [DATA_W-1:0] wdata,
  input logic              wlast,
  input logic              bvalid,
  input logic              bready,
  input logic              doneFlag
);

  logic startCmd;
  assign startCmd = regWrEn && (regWrAddr == 4'd0) && regWrStrb[4] &&
                    (regWrData[33:32] != 2'b00);

  // R3
  ar_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    arvalid && !arready |=> arvalid && $stable(araddr) && $stable(arlen));

  // R5
  aw_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    awvalid && !awready |=> awvalid && $stable(awaddr));

  // R6
  w_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    wvalid && !wready |=> wvalid && $stable(wdata) && $stable(wlast));

  // R11
  one_dir_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(arvalid && awvalid));

  // R7
  done_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneFlag) |-> $past((rvalid && rready && rlast) || (bvalid && bready) || startCmd));

endmodule

bind burst_copy_engine bce_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrAddr(regWrAddr),
  .regWrData(regWrData), .regWrStrb(regWrStrb), .arvalid(arvalid),
  .arready(arready), .araddr(araddr), .arlen(arlen), .awvalid(awvalid),
  .awready(awready), .awaddr(awaddr), .rvalid(rvalid), .rready(rready),
  .rlast(rlast), .wvalid(wvalid), .wready(wready), .wdata(wdata),
  .wlast(wlast), .bvalid(bvalid), .bready(bready), .doneFlag(doneFlag)
);

// File: tb/sim_burst_copy_engine.sv
`timescale 1ns/1ps
module sim_burst_copy_engine;

  logic clk = 1'b0, rstN = 1'b0;
  always #2 clk = ~clk;

  logic regWrEn = 0; logic [3:0] regWrAddr = 0, regRdAddr = 0;
  logic [63:0] regWrData = 0, regRdData; logic [7:0] regWrStrb = 0;
  logic arvalid, arready, rvalid, rready, rlast, awvalid, awready;
  logic wvalid, wready, wlast, bvalid, bready;
  logic [31:0] araddr, awaddr; logic [7:0] arlen, awlen;
  logic [2:0] arsize, awsize; logic [1:0] arburst, awburst, aruser, awuser;
  logic [3:0] arcache, awcache; logic [127:0] rdata, wdata; logic [15:0] wstrb;

  burst_copy_engine u0 (.*);

  int nChk = 0, nFail = 0;
  bit summaryDone = 0;
  int arCount, awCount, rBeatTotal, wBeatTotal, bCount, rLeft, wInBurst, bPend, cyc;
  logic [31:0] rAddrCur, expArBase, expAwBase, expSrcBase;
  logic [7:0] expLen; logic [3:0] expCache; logic [1:0] expUser;
  bit stallMode, prevStall; logic [127:0] prevData; logic prevLast;

  function automatic logic [127:0] pat(input logic [31:0] a);
    return {a, ~a, a ^ 32'hA5A5_A5A5, a + 32'h1};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // external memory slave model, inputs driven at the falling edge
  initial begin
    arready = 0; awready = 0; rvalid = 0; rlast = 0; rdata = '0;
    wready = 0; bvalid = 0;
    arCount = 0; awCount = 0; rBeatTotal = 0; wBeatTotal = 0; bCount = 0;
    rLeft = 0; wInBurst = 0; bPend = 0; cyc = 0; prevStall = 0; prevLast = 0;
    rAddrCur = 0; prevData = '0; stallMode = 0;
    forever begin
      @(negedge clk);
      if (!rstN) continue;
      arready = 1; awready = 1;
      rvalid = (rLeft > 0); rdata = pat(rAddrCur); rlast = (rLeft == 1);
      wready = stallMode ? (cyc % 3 == 2) : 1'b1; cyc++;
      bvalid = (bPend > 0);
      #1;
      if (prevStall)
        check(wvalid && wdata == prevData && wlast == prevLast, "R6 held beat", wdata, prevData);
      prevStall = wvalid && !wready; prevData = wdata; prevLast = wlast;
      if (rvalid && rready) begin rAddrCur += 16; rLeft--; rBeatTotal++; end
      if (arvalid && arready) begin
        check(araddr == expArBase + arCount * (expLen + 1) * 16, "R3 araddr", araddr,
              expArBase + arCount * (expLen + 1) * 16);
        check({arlen, arsize, arburst, arcache, aruser} == {expLen, 3'd4, 2'd1, expCache, expUser},
              "R3 ar fields", {arlen, arsize, arburst, arcache, aruser},
              {expLen, 3'd4, 2'd1, expCache, expUser});
        rLeft = arlen + 1; rAddrCur = araddr; arCount++;
      end
      if (awvalid && awready) begin
        check(awaddr == expAwBase + awCount * (expLen + 1) * 16, "R5 awaddr", awaddr,
              expAwBase + awCount * (expLen + 1) * 16);
        check(awlen == expLen && awcache == expCache && awuser == expUser, "R5 aw fields",
              {awlen, awcache, awuser}, {expLen, expCache, expUser});
        awCount++; wInBurst = 0;
      end
      if (wvalid && wready) begin
        check(wdata == pat(expSrcBase + wBeatTotal * 16), "R4/R5 wdata", wdata,
              pat(expSrcBase + wBeatTotal * 16));
        check(wlast == (wInBurst == expLen) && wstrb == 16'hFFFF, "R5 wlast/wstrb",
              {wlast, wstrb}, {(wInBurst == expLen), 16'hFFFF});
        if (wlast) bPend++;
        wInBurst++; wBeatTotal++;
      end
      if (bvalid && bready) begin bPend--; bCount++; end
    end
  end

  task automatic wrReg(input logic [3:0] a, input logic [63:0] d, input logic [7:0] s);
    @(negedge clk); regWrEn = 1; regWrAddr = a; regWrData = d; regWrStrb = s;
    @(negedge clk); regWrEn = 0; regWrStrb = 0;
  endtask

  task automatic rdReg(input logic [3:0] a, output logic [63:0] d);
    @(negedge clk); regRdAddr = a; #1 d = regRdData;
  endtask

  task automatic clearCounts();
    arCount = 0; awCount = 0; rBeatTotal = 0; wBeatTotal = 0; bCount = 0;
  endtask

  task automatic waitDone(output bit got);
    logic [63:0] d;
    got = 0;
    for (int i = 0; i < 2000 && !got; i++) begin
      rdReg(0, d);
      got = d[0];
    end
  endtask

  task automatic setup(input logic [31:0] ext, input logic [7:0] len,
                       input logic [15:0] cnt, input logic [10:0] ram);
    wrReg(1, {24'h0, len, ext}, 8'hFF);
    wrReg(2, {21'h0, ram, 16'h0, cnt}, 8'hFF);
  endtask

  task automatic test_reset();
    logic [63:0] d;
    check(!arvalid && !awvalid && !wvalid, "R1 valids low", {arvalid, awvalid, wvalid}, 0);
    for (int w = 0; w < 16; w++) begin
      rdReg(4'(w), d);
      check(d == 0, "R1 register zero", d, 0);
    end
  endtask

  task automatic test_regs();
    logic [63:0] d;
    wrReg(1, {32'h0000_0007, 32'h1234_5678}, 8'hFF);
    rdReg(1, d); check(d == {32'h7, 32'h1234_5678}, "R2 word1", d, {32'h7, 32'h1234_5678});
    wrReg(1, 64'hFFFF_FFFF_FFFF_FFFF, 8'h01);
    rdReg(1, d); check(d == {32'h7, 32'h1234_56FF}, "R2 byte strobe", d, {32'h7, 32'h1234_56FF});
    wrReg(14, {32'hF, 32'hFFFF_FFFF}, 8'hF0);
    rdReg(14, d); check(d == {32'hF, 32'h0}, "R2 cache high half", d, {32'hF, 32'h0});
    wrReg(15, {32'hFFFF_FFFF, 32'h2}, 8'h0F);
    rdReg(15, d); check(d == {32'h0, 32'h2}, "R2 user low half", d, {32'h0, 32'h2});
    wrReg(0, {32'h0000_0000, 32'h0}, 8'h00);
    rdReg(0, d); check(d[63:32] == 0, "R2 command reads 0", d, 0);
    expCache = 4'hF; expUser = 2'd2;
  endtask

  task automatic test_zero_count();
    logic [63:0] d;
    clearCounts();
    setup(32'h3000, 8'd0, 16'd0, 11'd0);
    wrReg(0, 64'h1 << 32, 8'hF0);
    rdReg(0, d);
    check(d[0] == 1'b1, "R10 done without bursts", d[0], 1);
    check(arCount == 0, "R10 no request", arCount, 0);
    repeat (5) @(negedge clk);
    rdReg(0, d); check(d[0] == 1'b1, "R8 done sticky", d[0], 1);
    wrReg(0, 64'h8000_0000 << 32, 8'hF0);
    rdReg(0, d); check(d[0] == 1'b0, "R8 done cleared", d[0], 0);
    // set and clear in the same cycle: set must win
    wrReg(0, 64'h8000_0001 << 32, 8'hF0);
    rdReg(0, d); check(d[0] == 1'b1, "R8 set wins over clear", d[0], 1);
    wrReg(0, 64'h8000_0000 << 32, 8'hF0);
  endtask

  task automatic test_read();
    bit got; logic [63:0] d;
    clearCounts();
    expArBase = 32'h1000; expLen = 8'd3;
    setup(32'h1000, 8'd3, 16'd3, 11'd1024);
    wrReg(0, 64'h1 << 32, 8'hF0);
    wrReg(0, 64'h2 << 32, 8'hF0);  // R9 start while busy
    rdReg(0, d); check(d[0] == 1'b0, "R7 not done early", d[0], 0);
    waitDone(got);
    check(got, "R7 read done seen", got, 1);
    check(rBeatTotal == 12, "R7 done after last beat", rBeatTotal, 12);
    check(arCount == 3, "R3 burst count", arCount, 3);
    check(awCount == 0, "R9 busy start ignored", awCount, 0);
    wrReg(0, 64'h8000_0000 << 32, 8'hF0);
  endtask

  task automatic test_write();
    bit got;
    clearCounts();
    expAwBase = 32'h8000; expSrcBase = 32'h1000; expLen = 8'd3;
    stallMode = 1;
    setup(32'h8000, 8'd3, 16'd3, 11'd1024);
    wrReg(0, 64'h2 << 32, 8'hF0);
    waitDone(got);
    check(got, "R7 write done seen", got, 1);
    check(bCount == 3 && wBeatTotal == 12, "R7 done after last response",
          {bCount, wBeatTotal}, {32'd3, 32'd12});
    check(awCount == 3, "R5 burst count", awCount, 3);
    stallMode = 0;
    wrReg(0, 64'h8000_0000 << 32, 8'hF0);
  endtask

  task automatic test_both_bits();
    bit got;
    clearCounts();
    expArBase = 32'h2000; expLen = 8'd0;
    setup(32'h2000, 8'd0, 16'd1, 11'd0);
    wrReg(0, 64'h3 << 32, 8'hF0);
    waitDone(got);
    check(arCount == 1 && awCount == 0, "R11 read has priority",
          {arCount, awCount}, {32'd1, 32'd0});
    wrReg(0, 64'h8000_0000 << 32, 8'hF0);
  endtask

  task automatic finishRun();
    if (!summaryDone) begin
      summaryDone = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    expArBase = 0; expAwBase = 0; expSrcBase = 0; expLen = 0; expCache = 0; expUser = 0;
    repeat (4) @(negedge clk);
    rstN = 1;
    test_reset();
    test_regs();
    test_zero_count();
    test_read();
    test_write();
    test_both_bits();
    repeat (5) @(negedge clk);
    finishRun();
  end

endmodule